// File: doc/BRIEF.md
# Guarded Watchdog Timer

This block is a watchdog timer whose control registers defend themselves against stray software. A host reaches two byte-wide registers over a small register bus made of address, write data, write strobe, read strobe and read data. A side flag, `bit_op`, marks a write that comes from a single-bit manipulation instead of a full byte store. One register holds the mode: a fixed signature, a stop bit and an overflow tap. It takes exactly one byte write after reset. The other register is a key register. Storing the key value restarts the count. Any wrong use of either register asks for a reset.

The counter advances on `tick`, a one-cycle enable that a prescaler outside the block derives from a low-speed clock. When the count reaches the selected power-of-two limit, or when an access breaks the rules, the block raises `rst_req` for one clock. In that same edge it returns every piece of its own state to the power-up condition. Two inputs decide what happens in low-power states. `lp_state` says the chip is in a halt or stop state. `osc_lock` is a static option that says whether the low-speed oscillator may be stopped.

Top module: `wdt_guard`

## Requirements
- R1: While the mode register has not yet been written, a byte write to it whose bits [7:5] are not 3'b011 raises `rst_req`. A write with 3'b011 in those bits is stored whole and raises nothing.
- R2: After the mode register has accepted a byte write, a second byte write to it raises `rst_req`, unless the stop bit is set.
- R3: A write with `bit_op` high to the mode register (address 0) leaves its contents unchanged, raises nothing, and does not use up the single allowed write.
- R4: A byte write of any value other than 8'hAC to the key register (address 1) raises `rst_req`, unless the stop bit is set. A byte write of 8'hAC clears the count to zero and raises nothing.
- R5: A write with `bit_op` high to the key register raises `rst_req`, unless the stop bit is set.
- R6: Reading address 1 always returns 8'h9A. Reading address 0 returns the mode register. The mode register holds 8'h67 after reset.
- R7: When the accepted mode write has bit 4 set, counting stops, and the requests of R2, R4 and R5 are suppressed.
- R8: Mode bits [2:0] (sel) set the overflow point. `rst_req` rises after 2^(MIN_EXP+sel) counted ticks since the last clear. Before the first mode write, sel is 7.
- R9: With `osc_lock` low, ticks that arrive while `lp_state` is high are not counted. The count is held, not cleared, and counting resumes from it when `lp_state` falls.
- R10: With `osc_lock` high, ticks are counted whether `lp_state` is high or low.
- R11: `rst_req` lasts one clock. In the edge that raises it, the count, the mode register and the write-once state return to their reset values, so a new mode write is accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count enable from the prescaled low-speed clock |
| addr | input | ADDR_W | Register address: 0 is mode, 1 is key |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| bit_op | input | 1 | Marks the write as a single-bit manipulation |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, valid in the cycle rd_en is high |
| lp_state | input | 1 | Chip is in a halt or stop state |
| osc_lock | input | 1 | Static option: oscillator cannot be stopped |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The assertions assume that `osc_lock` does not change while counting is under way. They also assume that no new access violation and no overflow arrive in the cycle right after a request. The one-clock width of `rst_req` depends on that. The bench drives one bus access at a time. It holds `tick` low around every register access and every reset. It waits at least one idle cycle after each request before the next stimulus. Sweeps run in a small configuration with MIN_EXP of 3, so every tap, every signature pattern and both low-power options are covered within the cycle budget.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;
  localparam int unsigned NUM_TAPS = 8;
  localparam int unsigned SEL_W    = 3;
  localparam logic [7:0]  KEY_WRITE = 8'hAC;
  localparam logic [7:0]  KEY_READ  = 8'h9A;
  localparam logic [2:0]  MODE_SIG  = 3'b011;
  localparam logic [7:0]  MODE_INIT = 8'h67;
  localparam int unsigned OFF_BIT   = 4;

  // Number of counted ticks that ends one watchdog period for a tap.
  function automatic logic [31:0] tap_limit(input logic [SEL_W-1:0] sel,
                                            input int unsigned min_exp);
    return 32'd1 << (min_exp + 32'(sel));
  endfunction
endpackage

// File: rtl/wdt_guard_regs.sv
module wdt_guard_regs
  import wdt_guard_pkg::*;
#(
  parameter int ADDR_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kill,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              bit_op,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  output logic [7:0]        mode_q,
  output logic              written_q,
  output logic              stopped,
  output logic              viol,
  output logic              key_ok
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(1);

  logic mode_hit, key_hit, accept;

  assign mode_hit = wr_en && (addr == A_MODE);
  assign key_hit  = wr_en && (addr == A_KEY);
  assign stopped  = written_q && mode_q[OFF_BIT];

  always_comb begin
    viol   = 1'b0;
    accept = 1'b0;
    key_ok = 1'b0;
    if (mode_hit && !bit_op) begin
      if (written_q)                  viol   = !stopped;
      else if (wdata[7:5] != MODE_SIG) viol  = 1'b1;
      else                            accept = 1'b1;
    end
    if (key_hit) begin
      if (bit_op || (wdata != KEY_WRITE)) viol   = !stopped;
      else                                key_ok = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || kill) begin
      mode_q    <= MODE_INIT;
      written_q <= 1'b0;
    end else if (accept) begin
      mode_q    <= wdata;
      written_q <= 1'b1;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (rd_en) begin
      if (addr == A_MODE)     rdata = mode_q;
      else if (addr == A_KEY) rdata = KEY_READ;
    end
  end
endmodule

// File: rtl/wdt_guard_count.sv
module wdt_guard_count
  import wdt_guard_pkg::*;
#(
  parameter int unsigned MIN_EXP = 11,
  localparam int unsigned CNT_W  = MIN_EXP + NUM_TAPS - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill,
  input  logic             tick,
  input  logic             lp_state,
  input  logic             osc_lock,
  input  logic             stopped,
  input  logic             key_ok,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count,
  output logic             run,
  output logic             ovf
);
  logic [31:0] last;

  assign last = tap_limit(sel, MIN_EXP) - 32'd1;
  assign run  = tick && !stopped && (osc_lock || !lp_state);
  assign ovf  = run && (32'(count) == last);

  always_ff @(posedge clk) begin
    if (!rst_n || kill || key_ok) count <= '0;
    else if (run)                 count <= count + 1'b1;
  end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
#(
  parameter int unsigned MIN_EXP = 11,
  parameter int          ADDR_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              wr_en,
  input  logic              bit_op,
  input  logic              rd_en,
  output logic [7:0]        rdata,
  input  logic              lp_state,
  input  logic              osc_lock,
  output logic              rst_req
);
  localparam int unsigned CNT_W = MIN_EXP + NUM_TAPS - 1;

  logic [7:0]       mode_w;
  logic             written_w, stopped_w, viol_w, key_ok_w, ovf_w, run_w, kill_w;
  logic [CNT_W-1:0] count_w;

  assign kill_w = viol_w || ovf_w;

  wdt_guard_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .kill(kill_w), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .bit_op(bit_op), .rd_en(rd_en), .rdata(rdata),
    .mode_q(mode_w), .written_q(written_w), .stopped(stopped_w),
    .viol(viol_w), .key_ok(key_ok_w)
  );

  wdt_guard_count #(.MIN_EXP(MIN_EXP)) u_count (
    .clk(clk), .rst_n(rst_n), .kill(kill_w), .tick(tick),
    .lp_state(lp_state), .osc_lock(osc_lock), .stopped(stopped_w),
    .key_ok(key_ok_w), .sel(mode_w[SEL_W-1:0]), .count(count_w),
    .run(run_w), .ovf(ovf_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= kill_w;
  end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
  import wdt_guard_pkg::*;
#(
  parameter int unsigned MIN_EXP = 11,
  parameter int          ADDR_W  = 1,
  localparam int unsigned CNT_W  = MIN_EXP + NUM_TAPS - 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              bit_op,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              lp_state,
  input logic              osc_lock,
  input logic              rst_req,
  input logic [7:0]        mode_w,
  input logic              written_w,
  input logic              stopped_w,
  input logic              key_ok_w,
  input logic              kill_w,
  input logic [CNT_W-1:0]  count_w
);
  a_r11_reinit: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (count_w == '0) && !written_w && (mode_w == MODE_INIT));

  a_r11_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req && !kill_w) |=> !rst_req);

  a_r3_bit_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bit_op && addr == ADDR_W'(0) && !kill_w) |=> $stable(mode_w) && !rst_req);

  a_r2_second_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bit_op && addr == ADDR_W'(0) && written_w && !stopped_w) |=> rst_req);

  a_r5_bit_key: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bit_op && addr == ADDR_W'(1) && !stopped_w) |=> rst_req);

  a_r6_key_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(1)) |-> rdata == KEY_READ);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_state && !osc_lock && !kill_w && !key_ok_w) |=> $stable(count_w));

  a_r7_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped_w && !kill_w && !key_ok_w) |=> $stable(count_w) && !rst_req);

  a_r8_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(count_w) < tap_limit(mode_w[SEL_W-1:0], MIN_EXP));
endmodule

bind wdt_guard wdt_guard_chk #(.MIN_EXP(MIN_EXP), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .bit_op(bit_op),
  .rd_en(rd_en), .rdata(rdata), .lp_state(lp_state), .osc_lock(osc_lock),
  .rst_req(rst_req), .mode_w(mode_w), .written_w(written_w),
  .stopped_w(stopped_w), .key_ok_w(key_ok_w), .kill_w(kill_w),
  .count_w(count_w)
);

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  localparam int unsigned MEXP = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [0:0] addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       wr_en = 1'b0, bit_op = 1'b0, rd_en = 1'b0;
  logic       lp_state = 1'b0, osc_lock = 1'b0;
  logic [7:0] rdata;
  logic       rst_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_guard #(.MIN_EXP(MEXP), .ADDR_W(1)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .bit_op(bit_op), .rd_en(rd_en), .rdata(rdata),
    .lp_state(lp_state), .osc_lock(osc_lock), .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive one write at a negedge; returns after the capturing edge.
  task automatic wr(input logic a, input logic [7:0] d, input logic b);
    addr = a; wdata = d; bit_op = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bit_op = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  // Apply up to n ticks; hit is the index of the tick after which rst_req was seen.
  task automatic ticks(input int n, output int hit);
    hit = 0;
    for (int i = 1; i <= n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      if (rst_req) begin
        hit = i;
        break;
      end
    end
    tick = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int hit;
    do_reset();

    // R6 reset state
    check("R11 reset rst_req", int'(rst_req), 0);
    rd(1'b0, v); check("R6 mode reset value", v, 8'h67);
    rd(1'b1, v); check("R6 key read", v, 8'h9A);

    // R8 default tap is sel 7
    ticks(2000, hit); check("R8 default tap", hit, 1 << (MEXP + 7));
    @(negedge clk); check("R11 pulse width", int'(rst_req), 0);

    // R8 sweep of every tap
    for (int s = 0; s < 8; s++) begin
      do_reset();
      wr(1'b0, 8'h60 | 8'(s), 1'b0);
      check("R1 accepted write", int'(rst_req), 0);
      rd(1'b0, v); check("R1 stored mode", v, 8'h60 | s);
      ticks(1100, hit); check("R8 tap sweep", hit, 1 << (MEXP + s));
      @(negedge clk); check("R11 one cycle", int'(rst_req), 0);
      rd(1'b0, v); check("R11 mode reinit", v, 8'h67);
    end

    // R1 sweep of all signature patterns
    for (int p = 0; p < 8; p++) begin
      do_reset();
      wr(1'b0, {3'(p), 5'b00010}, 1'b0);
      check("R1 signature", int'(rst_req), (p == 3) ? 0 : 1);
    end

    // R3 bit write to mode, then R2 write-once and R11 reinit
    do_reset();
    wr(1'b0, 8'h61, 1'b1); check("R3 no request", int'(rst_req), 0);
    rd(1'b0, v); check("R3 unchanged", v, 8'h67);
    wr(1'b0, 8'h62, 1'b0); check("R3 write still allowed", int'(rst_req), 0);
    rd(1'b0, v); check("R3 byte write stored", v, 8'h62);
    wr(1'b0, 8'h63, 1'b0); check("R2 second write", int'(rst_req), 1);
    @(negedge clk);
    rd(1'b0, v); check("R11 mode after request", v, 8'h67);
    wr(1'b0, 8'h64, 1'b0); check("R11 write accepted again", int'(rst_req), 0);
    rd(1'b0, v); check("R11 new mode", v, 8'h64);

    // R4 bad key, R5 bit key
    do_reset();
    wr(1'b1, 8'hAB, 1'b0); check("R4 bad key", int'(rst_req), 1);
    do_reset();
    wr(1'b1, 8'hAC, 1'b1); check("R5 bit key", int'(rst_req), 1);

    // R4 good key clears the count
    do_reset();
    wr(1'b0, 8'h62, 1'b0);
    ticks(20, hit); check("R4 before key", hit, 0);
    wr(1'b1, 8'hAC, 1'b0); check("R4 good key no request", int'(rst_req), 0);
    rd(1'b1, v); check("R6 key read after write", v, 8'h9A);
    ticks(40, hit); check("R4 cleared count", hit, 32);

    // R7 stop bit
    do_reset();
    wr(1'b0, 8'h72, 1'b0);
    wr(1'b0, 8'h00, 1'b0); check("R7 second write tolerated", int'(rst_req), 0);
    wr(1'b1, 8'hAC, 1'b1); check("R7 bit key tolerated", int'(rst_req), 0);
    wr(1'b1, 8'h55, 1'b0); check("R7 bad key tolerated", int'(rst_req), 0);
    rd(1'b0, v); check("R7 mode kept", v, 8'h72);
    ticks(2000, hit); check("R7 counting stopped", hit, 0);

    // R10 oscillator locked: count in low power
    do_reset();
    osc_lock = 1'b1; lp_state = 1'b1;
    wr(1'b0, 8'h62, 1'b0);
    ticks(40, hit); check("R10 counts in low power", hit, 32);
    @(negedge clk);

    // R9 oscillator stoppable: hold in low power
    do_reset();
    osc_lock = 1'b0; lp_state = 1'b0;
    wr(1'b0, 8'h62, 1'b0);
    ticks(20, hit); check("R9 before low power", hit, 0);
    lp_state = 1'b1;
    ticks(100, hit); check("R9 frozen", hit, 0);
    lp_state = 1'b0;
    ticks(40, hit); check("R9 resumes held count", hit, 12);
    @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule